// File: doc/BRIEF.md
# Posted Write Buffer with Burst Merging

This block sits between a write-through data cache and the one downstream bus port that the cache shares with its read-miss traffic. The processor posts writes into a small FIFO and keeps running while the FIFO has room. A sequencer drains the FIFO onto the bus. It packs runs of word-contiguous writes into one multi-beat burst, and it keeps every transaction in the order the processor produced it.

The interconnect may return responses out of order. The block therefore allows only one transaction in flight. After the last command beat of a transaction it sends nothing more until that transaction's single response has come back. A read miss uses a level request. It waits until every earlier buffered write has been sent and answered, goes out as a one-beat read, and completes with a one-cycle done strobe that carries the read data and the error bit. A write response that carries an error produces a one-cycle error pulse toward the processor.

The sequencer has five states:
- `S_IDLE` chooses the next job.
- `S_WBEAT` presents write beats.
- `S_WRSP` waits for a write response.
- `S_RCMD` presents the read command.
- `S_RRSP` waits for the read response.

The transitions are:
- `S_IDLE` goes to `S_WBEAT` when the FIFO holds any entry. Otherwise it goes to `S_RCMD` when a read is requested.
- `S_WBEAT` goes to `S_WRSP` when a beat marked last is accepted.
- `S_WRSP` goes to `S_IDLE` on a response.
- `S_RCMD` goes to `S_RRSP` when the command is accepted.
- `S_RRSP` goes to `S_IDLE` on a response.

Top module: `posted_write_merger`

## Requirements
- R1: After reset, `wr_ready` is 1, and `cmd_valid`, `wr_err` and `rd_done` are 0.
- R2: `wr_ready` is 1 exactly when the FIFO holds fewer than DEPTH (default 8) entries and `rd_req` is 0.
- R10: While `rd_req` is 1, `wr_ready` is 0, so that no write can overtake a pending read.
- R3: Write beats appear on the bus with `cmd_write`=1. Their address and data are those of the accepted writes, in acceptance order, with none lost or repeated.
- R4: `cmd_last` marks the final beat of a burst. A beat is last when any of these holds: the next buffered entry's address is not this address plus DW/8 (4 bytes by default), the FIFO holds only this entry, or the beat is number MAX_BURST (default 4) of the burst.
- R5: While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields stay unchanged. A `cmd_last` that has been shown stays 1 until that beat is taken.
- R6: After a beat with `cmd_last`=1 is accepted, `cmd_valid` stays 0 until the response to that transaction arrives on `rsp_valid`.
- R7: A read goes out only when the FIFO is empty and no write is in flight. It is one beat, with `cmd_write`=0, `cmd_last`=1 and `cmd_addr`=`rd_addr`.
- R8: `rd_done` is 1 only in the cycle the read response arrives. In that cycle `rd_rdata`=`rsp_rdata` and `rd_err`=`rsp_err`.
- R9: `wr_err` is a one-cycle pulse in the cycle a write-burst response arrives with `rsp_err`=1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor posts a write |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | AW | Byte address of the posted write |
| wr_data | input | DW | Data of the posted write |
| rd_req | input | 1 | Read miss pending (held until `rd_done`) |
| rd_addr | input | AW | Read miss address, held with `rd_req` |
| rd_done | output | 1 | Read response strobe |
| rd_rdata | output | DW | Read data |
| rd_err | output | 1 | Read response error |
| wr_err | output | 1 | Posted-write error pulse |
| cmd_valid | output | 1 | Bus command beat valid |
| cmd_ready | input | 1 | Bus accepts the beat |
| cmd_write | output | 1 | 1 = write beat, 0 = read |
| cmd_last | output | 1 | Final beat of the transaction |
| cmd_addr | output | AW | Beat address |
| cmd_wdata | output | DW | Beat write data |
| rsp_valid | input | 1 | Response for the outstanding transaction |
| rsp_err | input | 1 | Response error flag |
| rsp_rdata | input | DW | Response read data |

## Verification
The merge rule is tried with four kinds of write stream:
- An unbroken ascending run shows that splitting happens at the maximum burst length.
- Scrambled, non-adjacent addresses show that every gap ends a burst.
- A run posted while the bus stalls fills the FIFO, which exposes the full flag and a last flag that must stay held while new entries arrive behind the head.
- Random mixes of short runs and gaps, with random bus readiness and response delays, show whether a burst ends because the FIFO drained or because of contiguity.

Reads issued behind buffered writes show the ordering rule. Error responses on both kinds of transaction show that the error pulse is steered only to writes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WBEAT = 3'd1,
        S_WRSP  = 3'd2,
        S_RCMD  = 3'd3,
        S_RRSP  = 3'd4
    } pwm_state_e;

endpackage

// File: rtl/pwm_fifo.sv
module pwm_fifo #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [AW-1:0] next_addr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wptr, rptr, rptr_nx, wptr_nx;

    assign rptr_nx = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
    assign wptr_nx = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wptr] <= push_addr;
            data_q[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr_nx;
            if (pop)  rptr <= rptr_nx;
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_addr = addr_q[rptr];
    assign head_data = data_q[rptr];
    assign next_addr = addr_q[rptr_nx];
    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/pwm_merge.sv
module pwm_merge #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int DEPTH     = 8,
    parameter int MAX_BURST = 4,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int BW       = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1,
    localparam int STRIDE   = DW / 8
) (
    input  logic [AW-1:0] head_addr,
    input  logic [AW-1:0] next_addr,
    input  logic [CW-1:0] count,
    input  logic [BW-1:0] beat,
    input  logic          hold,
    output logic          burst_last
);

    logic gap, only_one, at_cap;

    assign gap        = (next_addr != head_addr + AW'(STRIDE));
    assign only_one   = (count <= CW'(1));
    assign at_cap     = (beat == BW'(MAX_BURST - 1));
    assign burst_last = hold | gap | only_one | at_cap;

endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
    import pwm_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int MAX_BURST = 4,
    localparam int BW       = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_empty,
    input  logic          burst_last,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          cmd_ready,
    input  logic          rsp_valid,
    input  logic          rsp_err,
    input  logic [DW-1:0] rsp_rdata,
    output logic          cmd_valid,
    output logic          cmd_write,
    output logic          cmd_last,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata,
    output logic          pop,
    output logic [BW-1:0] beat,
    output logic          hold,
    output logic          rd_done,
    output logic [DW-1:0] rd_rdata,
    output logic          rd_err,
    output logic          wr_err
);

    pwm_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            beat  <= '0;
            hold  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_WBEAT) begin
                if (cmd_ready) begin
                    hold <= 1'b0;
                    beat <= burst_last ? '0 : beat + BW'(1);
                end else begin
                    hold <= burst_last;
                end
            end else begin
                beat <= '0;
                hold <= 1'b0;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (!fifo_empty)  state_nx = S_WBEAT;
                else if (rd_req)  state_nx = S_RCMD;
            end
            S_WBEAT: if (cmd_ready && burst_last) state_nx = S_WRSP;
            S_WRSP:  if (rsp_valid) state_nx = S_IDLE;
            S_RCMD:  if (cmd_ready) state_nx = S_RRSP;
            S_RRSP:  if (rsp_valid) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_last  = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        pop       = 1'b0;
        rd_done   = 1'b0;
        rd_rdata  = '0;
        rd_err    = 1'b0;
        wr_err    = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_WBEAT: begin
                cmd_valid = 1'b1;
                cmd_write = 1'b1;
                cmd_last  = burst_last;
                cmd_addr  = head_addr;
                cmd_wdata = head_data;
                pop       = cmd_ready;
            end
            S_WRSP: wr_err = rsp_valid & rsp_err;
            S_RCMD: begin
                cmd_valid = 1'b1;
                cmd_last  = 1'b1;
                cmd_addr  = rd_addr;
            end
            S_RRSP: begin
                rd_done  = rsp_valid;
                rd_rdata = rsp_rdata;
                rd_err   = rsp_err;
            end
            default: ;
        endcase
    end

    assert_cmd_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
            $stable(cmd_wdata) && $stable(cmd_write) && $stable(cmd_last)));

    assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_last) |=> !cmd_valid);

    assert_read_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write) |-> fifo_empty);

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> !wr_err);

endmodule

// File: rtl/posted_write_merger.sv
module posted_write_merger #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int DEPTH     = 8,
    parameter int MAX_BURST = 4,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int BW       = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_done,
    output logic [DW-1:0] rd_rdata,
    output logic          rd_err,
    output logic          wr_err,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic          cmd_write,
    output logic          cmd_last,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata,
    input  logic          rsp_valid,
    input  logic          rsp_err,
    input  logic [DW-1:0] rsp_rdata
);

    logic          push, pop, full, empty, hold, burst_last;
    logic [AW-1:0] head_addr, next_addr;
    logic [DW-1:0] head_data;
    logic [CW-1:0] count;
    logic [BW-1:0] beat;

    assign wr_ready = !full && !rd_req;
    assign push     = wr_valid && wr_ready;

    pwm_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .next_addr (next_addr),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    pwm_merge #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .MAX_BURST(MAX_BURST)) u_merge (
        .head_addr  (head_addr),
        .next_addr  (next_addr),
        .count      (count),
        .beat       (beat),
        .hold       (hold),
        .burst_last (burst_last)
    );

    pwm_seq #(.AW(AW), .DW(DW), .MAX_BURST(MAX_BURST)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (empty),
        .burst_last (burst_last),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .cmd_ready  (cmd_ready),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_last   (cmd_last),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .pop        (pop),
        .beat       (beat),
        .hold       (hold),
        .rd_done    (rd_done),
        .rd_rdata   (rd_rdata),
        .rd_err     (rd_err),
        .wr_err     (wr_err)
    );

    assert_hold_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done) |=> !push);

endmodule

// File: tb/posted_write_merger_tb.sv
module posted_write_merger_tb;

    localparam int DEPTH = 8;
    localparam int MAXB  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, rd_req = 1'b0, cmd_ready = 1'b0;
    logic        rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rsp_rdata = '0;
    logic        wr_ready, rd_done, rd_err, wr_err;
    logic        cmd_valid, cmd_write, cmd_last;
    logic [31:0] rd_rdata, cmd_addr, cmd_wdata;

    always #2 clk = ~clk;

    posted_write_merger #(.DEPTH(DEPTH), .MAX_BURST(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_rdata(rd_rdata),
        .rd_err(rd_err), .wr_err(wr_err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_last(cmd_last), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    int unsigned n_checks = 0, n_errors = 0;

    // stimulus and responder state
    logic        wv = 0, rr = 0, err_next = 0;
    logic [31:0] wa = 0, wd = 0, ra = 0;
    int          rmode = 0;
    int          rsp_delay = 1;
    logic [15:0] lfsr = 16'hACE1;
    logic        out_pend = 0;
    int          rsp_cnt = 0;
    logic        got_acc = 0, got_done = 0;

    // reference model
    logic [63:0] mq[$];
    int          phase = 0;
    int          mbeat = 0;
    logic        mhold = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cycle();
        logic        e_valid, e_last, e_ready, txn_done;
        logic [31:0] e_addr, e_data;
        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_data = wd;
        rd_req = rr; rd_addr = ra;
        cmd_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'b0 : lfsr[0];
        rsp_valid = out_pend && (rsp_cnt == 0);
        rsp_err   = err_next;
        rsp_rdata = ~ra;
        #1;
        e_ready = (mq.size() < DEPTH) && !rr;
        chk(wr_ready == e_ready, rr ? "R10" : "R2", "wr_ready", 32'(wr_ready), 32'(e_ready));
        e_valid = (phase == 1) || (phase == 3);
        chk(cmd_valid == e_valid, (phase == 2 || phase == 4) ? "R6" : "R3", "cmd_valid",
            32'(cmd_valid), 32'(e_valid));
        e_last = 1'b0;
        if (phase == 1) begin
            e_addr = mq[0][63:32];
            e_data = mq[0][31:0];
            e_last = mhold || (mbeat == MAXB - 1) || (mq.size() == 1) ||
                     (mq[1][63:32] != e_addr + 32'd4);
            chk(cmd_write == 1'b1, "R3", "cmd_write", 32'(cmd_write), 32'd1);
            chk(cmd_addr == e_addr, "R3", "cmd_addr", cmd_addr, e_addr);
            chk(cmd_wdata == e_data, "R3", "cmd_wdata", cmd_wdata, e_data);
            chk(cmd_last == e_last, mhold ? "R5" : "R4", "cmd_last", 32'(cmd_last), 32'(e_last));
        end
        if (phase == 3) begin
            e_last = 1'b1;
            chk(mq.size() == 0, "R7", "fifo empty at read", 32'(mq.size()), 32'd0);
            chk(cmd_write == 1'b0, "R7", "cmd_write", 32'(cmd_write), 32'd0);
            chk(cmd_last == 1'b1, "R7", "cmd_last", 32'(cmd_last), 32'd1);
            chk(cmd_addr == ra, "R7", "cmd_addr", cmd_addr, ra);
        end
        chk(wr_err == (phase == 2 && rsp_valid && rsp_err), "R9", "wr_err",
            32'(wr_err), 32'(phase == 2 && rsp_valid && rsp_err));
        chk(rd_done == (phase == 4 && rsp_valid), "R8", "rd_done",
            32'(rd_done), 32'(phase == 4 && rsp_valid));
        if (phase == 4 && rsp_valid) begin
            chk(rd_rdata == ~ra, "R8", "rd_rdata", rd_rdata, ~ra);
            chk(rd_err == err_next, "R8", "rd_err", 32'(rd_err), 32'(err_next));
        end
        // model advance for the coming edge
        got_acc  = wv && e_ready;
        got_done = (phase == 4) && rsp_valid;
        txn_done = 1'b0;
        case (phase)
            0: if (mq.size() > 0) begin phase = 1; mbeat = 0; mhold = 0; end
               else if (rr) phase = 3;
            1: if (cmd_ready) begin
                   void'(mq.pop_front());
                   mhold = 0;
                   if (e_last) begin phase = 2; mbeat = 0; txn_done = 1; end
                   else mbeat++;
               end else mhold = e_last;
            2: if (rsp_valid) phase = 0;
            3: if (cmd_ready) begin phase = 4; txn_done = 1; end
            4: if (rsp_valid) phase = 0;
            default: phase = 0;
        endcase
        if (got_acc) mq.push_back({wa, wd});
        if (rsp_valid) out_pend = 0;
        else if (out_pend && rsp_cnt > 0) rsp_cnt--;
        if (txn_done) begin out_pend = 1; rsp_cnt = rsp_delay; end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        wv = 1; wa = a; wd = d;
        do cycle(); while (!got_acc);
        wv = 0;
    endtask

    task automatic do_read(input logic [31:0] a);
        rr = 1; ra = a;
        do cycle(); while (!got_done);
        rr = 0;
    endtask

    task automatic drain();
        do cycle(); while (mq.size() != 0 || phase != 0 || out_pend);
    endtask

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset
        chk(wr_ready == 1'b1, "R1", "wr_ready", 32'(wr_ready), 32'd1);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid", 32'(cmd_valid), 32'd0);
        chk(wr_err == 1'b0, "R1", "wr_err", 32'(wr_err), 32'd0);
        chk(rd_done == 1'b0, "R1", "rd_done", 32'(rd_done), 32'd0);

        // contiguous run, bus always ready: bursts cut at MAXB (R4)
        rmode = 0; rsp_delay = 2;
        for (int i = 0; i < 6; i++) do_write(32'h100 + 32'(4 * i), 32'hA000 + 32'(i));
        drain();

        // fill while bus stalled: full flag (R2) and held last (R5)
        rmode = 1;
        for (int i = 0; i < DEPTH; i++) do_write(32'h200 + 32'(4 * i), 32'hB000 + 32'(i));
        repeat (3) cycle();
        rmode = 2;
        do_write(32'h220, 32'hB008);
        drain();

        // scattered addresses: every gap ends a burst (R4)
        rmode = 0; rsp_delay = 0;
        do_write(32'h300, 1); do_write(32'h308, 2); do_write(32'h304, 3);
        do_write(32'h30C, 4); do_write(32'h310, 5);
        drain();

        // read behind buffered writes (R7, R8, R10)
        rmode = 2; rsp_delay = 3;
        do_write(32'h400, 7); do_write(32'h404, 8); do_write(32'h40C, 9);
        do_read(32'h5000);
        drain();

        // error responses (R9 on writes, R8 on reads)
        err_next = 1;
        do_write(32'h600, 1); do_write(32'h604, 2);
        drain();
        do_read(32'h6100);
        drain();
        err_next = 0;

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] base;
            base = 32'h1000 + 32'(($urandom % 64) * 4);
            rsp_delay = $urandom % 4;
            err_next = (($urandom % 8) == 0);
            if (($urandom % 10) == 0) do_read(base ^ 32'h8000);
            else begin
                int len = 1 + ($urandom % 6);
                for (int k = 0; k < len; k++) do_write(base + 32'(4 * k), $urandom);
            end
            if (($urandom % 3) == 0) cycle();
        end
        err_next = 0;
        drain();
        chk(mq.size() == 0, "R3", "all writes sent", 32'(mq.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule